// File: doc/BRIEF.md
# Sound Coprocessor Address Decoder with Banked Host Window

This block sits between the 16-bit address bus of a sound coprocessor and the devices that coprocessor can reach. Each read or write strobe is classified by address and steered to one of five targets: an internal byte-wide work RAM, the four ports of an FM synthesizer, a write-only tone generator port, a serially loaded bank register, or a 32 KB window that opens onto a 24-bit host address space. Any address that matches none of these targets is unmapped.

The window path forms a host address from the bank register and the coprocessor address. It also reports which byte lane of the 16-bit host word is meant, and it copies write bytes onto both halves of the host data bus. The bank register is loaded one bit per write. Each write shifts a new bit in at the top, so nine writes set the whole bank.

Device strobes, the host request and its address are registered and appear one clock after the coprocessor strobe. Read data comes back on a separate return port two clocks after the strobe, flagged by a one-cycle valid pulse. This fixed latency suits a block RAM and a host that answers within one cycle.

Top module: `snd_bus_decoder`

## Requirements
- R1: After reset, every strobe output, `rd_valid`, `rd_data`, `host_addr` and the bank register are zero.
- R2: Addresses with bits [15:13] equal to 000 access the work RAM at byte index addr[12:0]. A read returns the byte last written to that index.
- R3: A read of 0x4000, 0x4001, 0x4002 or 0x4003 pulses `fm_rd` one clock after the strobe and returns the `fm_status` value present during that pulse.
- R4: A write to 0x4000 or 0x4002 pulses `fm_addr_we`, and a write to 0x4001 or 0x4003 pulses `fm_data_we`. In both cases `fm_port` equals addr[1] and `fm_wdata` equals the written byte.
- R5: A write to 0x6000 replaces the 9-bit bank with {data[0], bank[8:1]}. Writes to any other address leave the bank unchanged.
- R6: A write to 0x7F11, 0x7F13, 0x7F15 or 0x7F17 pulses `psg_we`, and `psg_wdata` equals the written byte.
- R7: An access with addr[15] set issues a host request with `host_addr` = {bank, addr[14:1], 0} and `host_lane` = addr[0].
- R8: A window read returns host_rdata[15:8] when addr[0] is 0 and host_rdata[7:0] when addr[0] is 1.
- R9: A window write pulses `host_wr` and drives the written byte onto both halves of `host_wdata`.
- R10: A read of an unmapped address returns 0xFF, and this includes reads of 0x6000 and of the tone port addresses. A write to an unmapped address raises no strobe and changes no state.
- R11: Each read raises `rd_valid` for exactly one cycle, two clocks after the strobe. A write never raises `rd_valid`.
- R12: When `cpu_rd` and `cpu_wr` are both high, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Coprocessor address |
| cpu_wdata | input | 8 | Coprocessor write byte |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| rd_data | output | 8 | Read return byte |
| rd_valid | output | 1 | Read return valid pulse |
| fm_rd | output | 1 | FM status read strobe |
| fm_addr_we | output | 1 | FM register-address write strobe |
| fm_data_we | output | 1 | FM register-data write strobe |
| fm_port | output | 1 | FM port select |
| fm_wdata | output | 8 | FM write byte |
| fm_status | input | 8 | FM status byte |
| psg_we | output | 1 | Tone generator write strobe |
| psg_wdata | output | 8 | Tone generator write byte |
| host_rd | output | 1 | Host window read request |
| host_wr | output | 1 | Host window write request |
| host_addr | output | 24 | Host byte address, always even |
| host_lane | output | 1 | 0 selects the high byte, 1 the low byte |
| host_wdata | output | 16 | Host write word, byte duplicated |
| host_rdata | input | 16 | Host read word |

## Verification
An error in the bank register does not appear at the ports when the bank is written. It shows up in `host_addr[23:15]` on the next window access, so the bench follows each run of bank writes with window accesses and compares against its own bank model. A decode error shows one clock after the strobe, either as a wrong or missing strobe or as `rd_data` differing two clocks later. An error in work RAM contents shows only when that index is read back. For this reason the random traffic keeps its RAM accesses to a small pool of indices that are rewritten and read again often.

// File: rtl/snd_dec_pkg.sv
package snd_dec_pkg;
  typedef enum logic [2:0] {
    RG_NONE, RG_RAM, RG_FM, RG_BANK, RG_PSG, RG_WIN
  } region_e;

  typedef enum logic [1:0] {
    SRC_NONE, SRC_RAM, SRC_FM, SRC_HOST
  } rsrc_e;

  localparam logic [15:0] FM_BASE   = 16'h4000;
  localparam logic [15:0] BANK_PORT = 16'h6000;
  localparam logic [15:0] PSG_BASE  = 16'h7F10;
  localparam int          RAM_SPAN_W = 13;
endpackage

// File: rtl/snd_addr_decode.sv
module snd_addr_decode
  import snd_dec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    region = RG_NONE;
    if (addr[TOP])
      region = RG_WIN;
    else if (addr[TOP:RAM_SPAN_W] == '0)
      region = RG_RAM;
    else if (addr[TOP:2] == FM_BASE[TOP:2])
      region = RG_FM;
    else if (addr == BANK_PORT[TOP:0])
      region = RG_BANK;
    else if (addr[TOP:3] == PSG_BASE[TOP:3] && addr[0])
      region = RG_PSG;
  end
endmodule

// File: rtl/snd_bank_shift.sv
module snd_bank_shift #(
  parameter int BANK_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [BANK_W-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (rst)
      bank_q <= '0;
    else if (shift_en)
      bank_q <= {bit_in, bank_q[BANK_W-1:1]};
  end
endmodule

// File: rtl/snd_work_ram.sv
module snd_work_ram #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/snd_bus_decoder.sv
module snd_bus_decoder
  import snd_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 13,
  parameter int BANK_W = 9,
  localparam int WIN_AW  = ADDR_W - 1,
  localparam int HOST_AW = BANK_W + WIN_AW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_valid,
  output logic                fm_rd,
  output logic                fm_addr_we,
  output logic                fm_data_we,
  output logic                fm_port,
  output logic [DATA_W-1:0]   fm_wdata,
  input  logic [DATA_W-1:0]   fm_status,
  output logic                psg_we,
  output logic [DATA_W-1:0]   psg_wdata,
  output logic                host_rd,
  output logic                host_wr,
  output logic [HOST_AW-1:0]  host_addr,
  output logic                host_lane,
  output logic [2*DATA_W-1:0] host_wdata,
  input  logic [2*DATA_W-1:0] host_rdata
);
  region_e           rgn;
  logic              wr_go, rd_go;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] ram_q;
  rsrc_e             s1_src;
  logic              s1_valid;
  logic              s1_lane;
  logic [DATA_W-1:0] ret_byte;

  assign wr_go = cpu_wr;
  assign rd_go = cpu_rd & ~cpu_wr;

  snd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (cpu_addr),
    .region (rgn)
  );

  snd_bank_shift #(.BANK_W(BANK_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .shift_en (wr_go && rgn == RG_BANK),
    .bit_in   (cpu_wdata[0]),
    .bank_q   (bank_q)
  );

  snd_work_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (wr_go && rgn == RG_RAM),
    .re    (rd_go && rgn == RG_RAM),
    .addr  (cpu_addr[RAM_AW-1:0]),
    .wdata (cpu_wdata),
    .q     (ram_q)
  );

  // Stage 1: device strobes, host request, read source
  always_ff @(posedge clk) begin
    if (rst) begin
      fm_rd      <= 1'b0;
      fm_addr_we <= 1'b0;
      fm_data_we <= 1'b0;
      fm_port    <= 1'b0;
      fm_wdata   <= '0;
      psg_we     <= 1'b0;
      psg_wdata  <= '0;
      host_rd    <= 1'b0;
      host_wr    <= 1'b0;
      host_addr  <= '0;
      host_lane  <= 1'b0;
      host_wdata <= '0;
      s1_valid   <= 1'b0;
      s1_src     <= SRC_NONE;
      s1_lane    <= 1'b0;
    end else begin
      fm_rd      <= rd_go && rgn == RG_FM;
      fm_addr_we <= wr_go && rgn == RG_FM && !cpu_addr[0];
      fm_data_we <= wr_go && rgn == RG_FM && cpu_addr[0];
      psg_we     <= wr_go && rgn == RG_PSG;
      host_rd    <= rd_go && rgn == RG_WIN;
      host_wr    <= wr_go && rgn == RG_WIN;
      s1_valid   <= rd_go;

      if (wr_go && rgn == RG_FM) begin
        fm_port  <= cpu_addr[1];
        fm_wdata <= cpu_wdata;
      end
      if (wr_go && rgn == RG_PSG)
        psg_wdata <= cpu_wdata;
      if ((rd_go || wr_go) && rgn == RG_WIN) begin
        host_addr <= {bank_q, cpu_addr[WIN_AW-1:1], 1'b0};
        host_lane <= cpu_addr[0];
      end
      if (wr_go && rgn == RG_WIN)
        host_wdata <= {2{cpu_wdata}};

      if (rd_go) begin
        s1_lane <= cpu_addr[0];
        unique case (rgn)
          RG_RAM:  s1_src <= SRC_RAM;
          RG_FM:   s1_src <= SRC_FM;
          RG_WIN:  s1_src <= SRC_HOST;
          default: s1_src <= SRC_NONE;
        endcase
      end
    end
  end

  // Return byte selection
  always_comb begin
    unique case (s1_src)
      SRC_RAM:  ret_byte = ram_q;
      SRC_FM:   ret_byte = fm_status;
      SRC_HOST: ret_byte = s1_lane ? host_rdata[DATA_W-1:0]
                                   : host_rdata[2*DATA_W-1:DATA_W];
      default:  ret_byte = '1;
    endcase
  end

  // Stage 2: read return
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= s1_valid;
      if (s1_valid) rd_data <= ret_byte;
    end
  end
endmodule

// File: rtl/snd_bus_decoder_chk.sv
module snd_bus_decoder_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int BANK_W  = 9,
  parameter int HOST_AW = 24
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   cpu_addr,
  input logic [DATA_W-1:0]   cpu_wdata,
  input logic                cpu_rd,
  input logic                cpu_wr,
  input logic                rd_valid,
  input logic                fm_rd,
  input logic                fm_addr_we,
  input logic                fm_data_we,
  input logic                psg_we,
  input logic                host_rd,
  input logic                host_wr,
  input logic [HOST_AW-1:0]  host_addr,
  input logic [2*DATA_W-1:0] host_wdata,
  input logic [BANK_W-1:0]   bank_q
);
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fm_rd, fm_addr_we, fm_data_we, psg_we, host_rd, host_wr}));

  // R11
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(cpu_rd && !cpu_wr, 2));

  // R11
  rd_valid_due_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr) |-> ##2 rd_valid);

  // R3
  fm_rd_ret_chk: assert property (@(posedge clk) disable iff (rst)
    fm_rd |=> rd_valid);

  // R5
  bank_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == 16'h6000) |=>
      bank_q == {$past(cpu_wdata[0]), $past(bank_q[BANK_W-1:1])});

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cpu_wr && cpu_addr == 16'h6000) |=> $stable(bank_q));

  // R7
  host_even_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd || host_wr) |-> host_addr[0] == 1'b0);

  // R9
  host_dup_chk: assert property (@(posedge clk) disable iff (rst)
    host_wr |-> host_wdata[2*DATA_W-1:DATA_W] == host_wdata[DATA_W-1:0]);
endmodule

bind snd_bus_decoder snd_bus_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .HOST_AW(HOST_AW)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rd_valid(rd_valid), .fm_rd(fm_rd),
  .fm_addr_we(fm_addr_we), .fm_data_we(fm_data_we), .psg_we(psg_we),
  .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .bank_q(bank_q)
);

// File: tb/sim_snd_bus_decoder.sv
`timescale 1ns/1ps
module sim_snd_bus_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        fm_rd, fm_addr_we, fm_data_we, fm_port;
  logic [7:0]  fm_wdata;
  logic [7:0]  fm_status = '0;
  logic        psg_we;
  logic [7:0]  psg_wdata;
  logic        host_rd, host_wr, host_lane;
  logic [23:0] host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] ram_m [8192];
  logic [8:0] bank_m = '0;

  always #4 clk = ~clk;

  function automatic logic [15:0] host_word(input logic [23:0] a);
    return {a[8:1] ^ 8'hA5, a[16:9] ^ 8'h3C};
  endfunction

  assign host_rdata = host_word(host_addr);

  snd_bus_decoder u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rd_data(rd_data), .rd_valid(rd_valid),
    .fm_rd(fm_rd), .fm_addr_we(fm_addr_we), .fm_data_we(fm_data_we),
    .fm_port(fm_port), .fm_wdata(fm_wdata), .fm_status(fm_status),
    .psg_we(psg_we), .psg_wdata(psg_wdata), .host_rd(host_rd),
    .host_wr(host_wr), .host_addr(host_addr), .host_lane(host_lane),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // 0 unmapped, 1 ram, 2 fm, 3 bank, 4 psg, 5 window
  function automatic int kind_of(input logic [15:0] a);
    if (a[15]) return 5;
    if (a < 16'h2000) return 1;
    if (a >= 16'h4000 && a <= 16'h4003) return 2;
    if (a == 16'h6000) return 3;
    if (a == 16'h7F11 || a == 16'h7F13 || a == 16'h7F15 || a == 16'h7F17) return 4;
    return 0;
  endfunction

  function automatic string tag_of(input int k, input bit w);
    case (k)
      1: return "R2";
      2: return w ? "R4" : "R3";
      3: return w ? "R5" : "R10";
      4: return w ? "R6" : "R10";
      5: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic access(input bit w, input bit r, input logic [15:0] a, input logic [7:0] d);
    int k;
    bit do_rd;
    logic [23:0] eha;
    logic [5:0] es;
    logic [7:0] exp_rd;
    logic [15:0] hw;
    string t;
    k = kind_of(a);
    do_rd = r && !w;
    t = (w && r) ? "R12" : tag_of(k, w);
    eha = {bank_m, a[14:1], 1'b0};
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_rd = r;
    fm_status = 8'($urandom);
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
    es = {do_rd && k == 2, w && k == 2 && !a[0], w && k == 2 && a[0],
          w && k == 4, do_rd && k == 5, w && k == 5};
    chk(t, {fm_rd, fm_addr_we, fm_data_we, psg_we, host_rd, host_wr}, es);
    chk("R11", rd_valid, 0);
    if (w && k == 2) begin
      chk("R4", fm_port, a[1]);
      chk("R4", fm_wdata, d);
    end
    if (w && k == 4) chk("R6", psg_wdata, d);
    if (k == 5 && (w || do_rd)) begin
      chk("R7", host_addr, eha);
      chk("R7", host_lane, a[0]);
      if (w) chk("R9", host_wdata, {d, d});
    end
    if (w && k == 1) ram_m[a[12:0]] = d;
    if (w && k == 3) bank_m = {d[0], bank_m[8:1]};
    if (do_rd) begin
      hw = host_word(eha);
      case (k)
        1: exp_rd = ram_m[a[12:0]];
        2: exp_rd = fm_status;
        5: exp_rd = a[0] ? hw[7:0] : hw[15:8];
        default: exp_rd = 8'hFF;
      endcase
      @(posedge clk);
      @(negedge clk);
      chk("R11", rd_valid, 1);
      chk(k == 5 ? "R8" : t, rd_data, exp_rd);
    end else begin
      @(posedge clk);
      @(negedge clk);
      chk("R11", rd_valid, 0);
    end
  endtask

  function automatic logic [15:0] pool_addr(input int idx);
    return 16'((idx * 253) % 8192);
  endfunction

  function automatic logic [15:0] unmapped_addr();
    case ($urandom % 6)
      0: return 16'h2000 | 16'($urandom % 16'h2000);
      1: return 16'h4004 + 16'($urandom % 16'h1FFC);
      2: return 16'h6001;
      3: return 16'h7F10;
      4: return 16'h7F12;
      default: return 16'h7F18;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", {fm_rd, fm_addr_we, fm_data_we, psg_we, host_rd, host_wr, rd_valid}, 0);
    chk("R1", rd_data, 0);
    chk("R1", host_addr, 0);
    access(0, 1, 16'h8000, 8'h00);
    chk("R1", host_addr[23:15], 0);

    // R2 fill the RAM pool
    for (int i = 0; i < 32; i++) access(1, 0, pool_addr(i), 8'($urandom));
    access(1, 0, 16'h1FFF, 8'h77);
    access(0, 1, 16'h1FFF, 8'h00);
    access(1, 0, 16'h0000, 8'h11);
    access(0, 1, 16'h0000, 8'h00);

    // R3 / R4 all FM ports
    for (int i = 0; i < 4; i++) access(0, 1, 16'h4000 + 16'(i), 8'h00);
    for (int i = 0; i < 4; i++) access(1, 0, 16'h4000 + 16'(i), 8'hC0 + 8'(i));

    // R6 all tone ports
    for (int i = 0; i < 4; i++) access(1, 0, 16'h7F11 + 16'(2 * i), 8'h90 + 8'(i));

    // R5 nine ones then check the bank value directly
    for (int i = 0; i < 9; i++) access(1, 0, 16'h6000, 8'hFF);
    access(0, 1, 16'h8001, 8'h00);
    chk("R5", host_addr[23:15], 9'h1FF);
    access(1, 0, 16'h6000, 8'hFE);
    access(1, 0, 16'h6000, 8'h02);
    access(0, 1, 16'hFFFE, 8'h00);
    chk("R5", host_addr[23:15], 9'h07F);

    // R9 window writes, both lanes
    access(1, 0, 16'h8000, 8'h3D);
    access(1, 0, 16'hC001, 8'hE2);

    // R10 unmapped and write-only reads
    access(0, 1, 16'h6000, 8'h00);
    access(0, 1, 16'h7F11, 8'h00);
    access(0, 1, 16'h2000, 8'h00);
    access(1, 0, 16'h6001, 8'h01);
    access(1, 0, 16'h7F12, 8'h55);
    access(0, 1, 16'h8000, 8'h00);

    // R12 both strobes high
    access(1, 1, pool_addr(3), 8'hA9);
    access(0, 1, pool_addr(3), 8'h00);
    access(1, 1, 16'h4000, 8'h12);
    access(1, 1, 16'h9000, 8'h34);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      bit w, r;
      case ($urandom % 8)
        0, 1: a = pool_addr(int'($urandom % 32));
        2:    a = 16'h4000 + 16'($urandom % 4);
        3:    a = 16'h6000;
        4:    a = 16'h7F11 + 16'(2 * ($urandom % 4));
        5, 6: a = 16'h8000 | 16'($urandom);
        default: a = unmapped_addr();
      endcase
      w = ($urandom % 2) == 1;
      r = !w || (($urandom % 16) == 0);
      access(w, r, a, 8'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule